// File: doc/BRIEF.md
# Shortened Double-Error-Correcting BCH Encoder

This block turns a 16-bit memory word into a 26-bit codeword that a later decoder can use to correct up to two flipped bits. The code is systematic. The data bits are passed through untouched, and ten check bits are placed above them. Each check bit is one XOR tree over the data bits selected by a column of the parity sub-matrix.

The parity sub-matrix comes from a cyclic double-error-correcting code of length 31 with 21 data positions. Row i of the parent matrix is the remainder of x^(10+i) divided by the generator polynomial g(x) = x^10 + x^9 + x^8 + x^6 + x^5 + x^3 + 1, computed modulo 2. The parent code is shortened to 16 data bits by dropping its five highest data positions, and the ten check bits stay as they are.

The matrix is computed at elaboration from the generator polynomial, so the hardware is only the XOR trees. The block has no clock and no state. It sits on the write path of a memory, in front of the array.

Top module: `dbchEncoder16`

## Requirements
- R1: Codeword bits [15:0] equal the data input bit for bit.
- R2: Codeword bit 16+j (j = 0..9) is the XOR of every data bit i for which bit j of (x^(10+i) mod g(x)) is 1, with g(x) = x^10+x^9+x^8+x^6+x^5+x^3+1 (hex 0x769).
- R3: Map data bit i to degree 10+i and check bit j to degree j. The resulting polynomial of degree below 26 divides exactly by g(x).
- R4: An all-zero data word gives an all-zero codeword.
- R5: The encoder is linear: the codeword of a XOR b equals the XOR of the codewords of a and b.
- R6: Every nonzero data word gives a codeword with at least five bits set.
- R7: The output depends only on the present input. A change of input shows at the output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 16 | Data word to be protected |
| codeOut | output | 26 | Codeword: check bits in [25:16], data in [15:0] |

## Verification
The property hardest to reach from the ports is the minimum weight of five. Low-weight codewords come only from a few sparse data words. The stimulus therefore walks every single-bit word, for which the check part alone must carry four or more ones. It then adds long runs of pseudo-random and patterned words, and for each one the codeword weight and its exact divisibility by g(x) are checked. Linearity is checked on chosen word pairs by applying a, b and a XOR b in turn.

// File: rtl/dbch_pkg.sv
package dbch_pkg;

  localparam int DefDataW  = 16;
  localparam int DefCheckW = 10;
  localparam logic [31:0] DefGenPoly = 32'h0000_0769;

  // remainder of x^deg modulo gen, chkW being the degree of gen
  function automatic logic [31:0] powRem(input int deg, input logic [31:0] gen,
                                         input int chkW);
    logic [31:0] acc;
    acc = 32'd1;
    for (int s = 0; s < deg; s++) begin
      acc = acc << 1;
      if (acc[chkW]) acc = acc ^ gen;
    end
    return acc & ~(32'hFFFF_FFFF << chkW);
  endfunction

  // remainder of an arbitrary polynomial (width polyW) modulo gen
  function automatic logic [31:0] polyRem(input logic [63:0] poly, input int polyW,
                                          input logic [31:0] gen, input int chkW);
    logic [63:0] work;
    logic [63:0] genWide;
    work = poly;
    genWide = {32'd0, gen};
    for (int deg = 63; deg >= 0; deg--) begin
      if (deg < polyW && deg >= chkW && work[deg]) work = work ^ (genWide << (deg - chkW));
    end
    return work[31:0] & ~(32'hFFFF_FFFF << chkW);
  endfunction

endpackage

// File: rtl/dbchParityMatrix.sv
module dbchParityMatrix #(
  parameter int DATA_W = dbch_pkg::DefDataW,
  parameter int CHECK_W = dbch_pkg::DefCheckW,
  parameter logic [31:0] GEN_POLY = dbch_pkg::DefGenPoly
) (
  output logic [CHECK_W-1:0][DATA_W-1:0] colMask
);

  // row i of the shortened matrix = x^(CHECK_W+i) mod g
  for (genvar i = 0; i < DATA_W; i++) begin : g_row
    localparam logic [31:0] ROW_BITS = dbch_pkg::powRem(CHECK_W + i, GEN_POLY, CHECK_W);
    for (genvar j = 0; j < CHECK_W; j++) begin : g_col
      assign colMask[j][i] = ROW_BITS[j];
    end
  end

endmodule

// File: rtl/dbchXorBank.sv
module dbchXorBank #(
  parameter int DATA_W = dbch_pkg::DefDataW,
  parameter int CHECK_W = dbch_pkg::DefCheckW,
  localparam int CODE_W = DATA_W + CHECK_W
) (
  input  logic [DATA_W-1:0]              dataIn,
  input  logic [CHECK_W-1:0][DATA_W-1:0] colMask,
  output logic [CODE_W-1:0]              codeword
);

  logic [CHECK_W-1:0] checkBits;

  for (genvar j = 0; j < CHECK_W; j++) begin : g_tree
    assign checkBits[j] = ^(dataIn & colMask[j]);
  end

  assign codeword = {checkBits, dataIn};

  always_comb begin
    if (dataIn == '0)
      p_zero_word_r4: assert (codeword == '0);
    if (dataIn != '0)
      p_min_weight_r6: assert ($countones(codeword) >= 5);
  end

endmodule

// File: rtl/dbchEncoder16.sv
module dbchEncoder16 #(
  parameter int DATA_W = dbch_pkg::DefDataW,
  parameter int CHECK_W = dbch_pkg::DefCheckW,
  parameter logic [31:0] GEN_POLY = dbch_pkg::DefGenPoly,
  localparam int CODE_W = DATA_W + CHECK_W
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CODE_W-1:0] codeOut
);

  logic [CHECK_W-1:0][DATA_W-1:0] colMask;
  logic [CODE_W-1:0] polyOrder;

  dbchParityMatrix #(.DATA_W(DATA_W), .CHECK_W(CHECK_W), .GEN_POLY(GEN_POLY)) matrix_i (
    .colMask(colMask)
  );

  dbchXorBank #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) bank_i (
    .dataIn(dataIn),
    .colMask(colMask),
    .codeword(codeOut)
  );

  // data at high degrees, check bits at low degrees
  assign polyOrder = {codeOut[DATA_W-1:0], codeOut[CODE_W-1:DATA_W]};

  always_comb begin
    p_passthru_r1: assert (codeOut[DATA_W-1:0] == dataIn);
    p_divisible_r3: assert (dbch_pkg::polyRem(64'(polyOrder), CODE_W, GEN_POLY, CHECK_W) == 32'd0);
  end

endmodule

// File: tb/dbchEncoder16_tb_top.sv
module dbchEncoder16_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] dataIn = '0;
  logic [25:0] codeOut;
  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] data;
    logic [25:0] expCode;
    string tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  dbchEncoder16 dut_i (.dataIn(dataIn), .codeOut(codeOut));

  function automatic logic [25:0] refCode(input logic [15:0] d);
    logic [25:0] m;
    m = {d, 10'd0};
    for (int k = 25; k >= 10; k--)
      if (m[k]) m = m ^ (26'h769 << (k - 10));
    return {m[9:0], d};
  endfunction

  function automatic logic [9:0] remOf(input logic [25:0] cw);
    logic [25:0] p;
    p = {cw[15:0], cw[25:16]};
    for (int k = 25; k >= 10; k--)
      if (p[k]) p = p ^ (26'h769 << (k - 10));
    return p[9:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [25:0] act,
                       input logic [25:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] d, input string tag);
    item_t it;
    @(posedge clk);
    dataIn <= d;
    it.data = d;
    it.expCode = refCode(d);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: sample half a cycle after each drive
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(codeOut[15:0] == it.data, {it.tag, " R1 data field"}, codeOut, it.expCode);
      check(codeOut == it.expCode, {it.tag, " R2 check bits"}, codeOut, it.expCode);
      check(remOf(codeOut) == 10'd0, {it.tag, " R3 divisible"}, codeOut, 26'(remOf(codeOut)));
      if (it.data != 16'd0)
        check($countones(codeOut) >= 5, {it.tag, " R6 weight"}, codeOut, it.expCode);
    end
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [25:0] ca, cb, cab;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(codeOut == 26'd0, "R4 reset state zero word", codeOut, 26'd0);

    drive(16'h0000, "R4 zero");
    for (int i = 0; i < 16; i++) drive(16'(1) << i, "R2 single bit");
    drive(16'hFFFF, "R2 all ones");
    drive(16'hAAAA, "R2 alt A");
    drive(16'h5555, "R2 alt 5");
    drive(16'h8001, "R6 ends");
    for (int i = 0; i < 15; i++) drive(16'h3 << i, "R6 adjacent pair");
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr, "R2 random");
    end
    @(posedge clk);
    @(negedge clk);

    // R5 linearity on chosen pairs
    for (int n = 0; n < 8; n++) begin
      logic [15:0] a, b;
      a = 16'h1234 * 16'(n + 1) ^ 16'h0F0F;
      b = 16'hBEEF >> n;
      @(posedge clk); dataIn <= a; @(negedge clk); ca = codeOut;
      @(posedge clk); dataIn <= b; @(negedge clk); cb = codeOut;
      @(posedge clk); dataIn <= a ^ b; @(negedge clk); cab = codeOut;
      check(cab == (ca ^ cb), "R5 linearity", cab, ca ^ cb);
    end

    // R7 no clock needed: change input between edges
    @(negedge clk);
    dataIn = 16'hC3A5;
    #1;
    check(codeOut == refCode(16'hC3A5), "R7 combinational response", codeOut, refCode(16'hC3A5));
    dataIn = 16'h0000;
    #0.5;
    check(codeOut == 26'd0, "R7 R4 return to zero", codeOut, 26'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule